// File: doc/BRIEF.md
# Sleep-State Entry/Exit Sequencer

This block sits in a host bridge and steps it into and out of a light sleep state and a deeper suspend-to-RAM state. A stop-grant cycle seen on the processor bus starts the entry. On entry, memory goes into self-refresh. Both DRAM channels have their clock enables pulled low, the command lines are held idle, and the clock trees are switched off. A retention flag tells the configuration registers to keep their contents.

Wake-up follows a fixed handshake order. First the southbridge clock-stop request must clear. After that the stop-clock request must clear. Only then are the clock trees enabled again. A settle window of `SETTLE_CYCLES` cycles follows. After the window, the sequencer waits until every enabled processor reports ready. It then leaves self-refresh. It waits for the memory side to acknowledge the self-refresh exit, and finally issues a one-cycle reconnect pulse to the processor bus. The deep variant runs through the same steps. The only difference is that it also raises a power-removed indication while the clocks are stopped.

Top module: `sleep_seq`

## Requirements
- R1: A one-cycle `stop_grant_i` pulse, sampled while running, puts the block to sleep from the next cycle. In that state `self_refresh_o` is 1.
- R2: While `self_refresh_o` is 1, `cke_a_o` and `cke_b_o` are 0 and `cmd_idle_o` is 1.
- R3: The clock trees (`clk_tree_en_o`) stay off until two conditions have been seen in order: `clk_stop_req_i` low while `stop_clk_req_i` is still high, and then `stop_clk_req_i` low.
- R4: If `stop_clk_req_i` falls while `clk_stop_req_i` is still high, the fall is ignored. The block stays asleep with the clocks off, even after `clk_stop_req_i` clears. Wake-up continues only after `stop_clk_req_i` has been raised again and then dropped.
- R5: Self-refresh is held until all `NPROC` bits of `proc_ready_i` are 1. A partial set of ready bits keeps `self_refresh_o` at 1.
- R6: After the clock trees come back, `self_refresh_o` stays 1 for at least `SETTLE_CYCLES` cycles. If all ready bits are already 1, it stays 1 for exactly `SETTLE_CYCLES`+1 cycles.
- R7: After self-refresh ends, `reconnect_o` stays 0 until `sr_exit_ack_i` is sampled high. On the next cycle it pulses high for exactly one cycle, and the block is then running again.
- R8: `cfg_retain_o` is 1 in every state except running. It is 1 throughout self-refresh.
- R9: If `deep_sleep_i` is 1 when the stop-grant is sampled, `pwr_removed_o` is 1 while the clock trees are off. Otherwise it stays 0.
- R10: A synchronous active-high `rst` gives the running state. In that state the clock trees and both clock enables are 1, and `self_refresh_o`, `reconnect_o`, `cfg_retain_o` and `pwr_removed_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_grant_i | input | 1 | Stop-grant cycle seen on the processor bus |
| deep_sleep_i | input | 1 | Selects suspend-to-RAM when sampled with stop-grant |
| clk_stop_req_i | input | 1 | Southbridge clock-stop request |
| stop_clk_req_i | input | 1 | Southbridge stop-clock request |
| proc_ready_i | input | NPROC | Per-processor ready |
| sr_exit_ack_i | input | 1 | Memory side acknowledges self-refresh exit |
| clk_tree_en_o | output | 1 | Clock tree enable |
| cke_a_o | output | 1 | DRAM clock enable, channel A |
| cke_b_o | output | 1 | DRAM clock enable, channel B |
| cmd_idle_o | output | 1 | Hold DRAM command lines idle |
| self_refresh_o | output | 1 | Self-refresh request |
| reconnect_o | output | 1 | One-cycle processor bus reconnect command |
| cfg_retain_o | output | 1 | Configuration registers must hold their contents |
| pwr_removed_o | output | 1 | Board power removed (deep state) |

## Verification
The assertions check the following on every cycle:
- clock enables are low and command lines idle during self-refresh;
- the clock trees only start after both southbridge requests were low in the previous cycle;
- self-refresh only ends with all ready bits high and a settle count behind it;
- reconnect only follows an acknowledge and lasts one cycle;
- the power-removed flag appears only while asleep.

Some properties can only be shown by the bench scenarios. These are that a wrong-order stop-clock drop is truly ignored until it is repeated, that the settle window has the exact length, that partial ready sets hold the block, and that the deep variant differs from the light one only in its power flag.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int NPROC = 2,
  parameter int SETTLE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_grant_i,
  input  logic             deep_sleep_i,
  input  logic             clk_stop_req_i,
  input  logic             stop_clk_req_i,
  input  logic [NPROC-1:0] proc_ready_i,
  input  logic             sr_exit_ack_i,
  output logic             clk_tree_en_o,
  output logic             cke_a_o,
  output logic             cke_b_o,
  output logic             cmd_idle_o,
  output logic             self_refresh_o,
  output logic             reconnect_o,
  output logic             cfg_retain_o,
  output logic             pwr_removed_o
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [2:0] {
    ST_RUN, ST_SLEEP, ST_WAIT_SC, ST_SETTLE, ST_WAIT_RDY, ST_SR_EXIT, ST_RECON
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          deep_q;

  wire all_rdy    = &proc_ready_i;
  wire clocks_off = (state == ST_SLEEP) || (state == ST_WAIT_SC);
  wire in_sr      = clocks_off || (state == ST_SETTLE) || (state == ST_WAIT_RDY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_RUN;
      cnt    <= '0;
      deep_q <= 1'b0;
    end else begin
      case (state)
        ST_RUN: if (stop_grant_i) begin
          state  <= ST_SLEEP;
          deep_q <= deep_sleep_i;
        end
        ST_SLEEP:   if (!clk_stop_req_i && stop_clk_req_i) state <= ST_WAIT_SC;
        ST_WAIT_SC: if (!stop_clk_req_i) begin
          state <= ST_SETTLE;
          cnt   <= '0;
        end
        ST_SETTLE:
          if (cnt == CW'(SETTLE_CYCLES - 1)) state <= ST_WAIT_RDY;
          else cnt <= cnt + 1'b1;
        ST_WAIT_RDY: if (all_rdy) state <= ST_SR_EXIT;
        ST_SR_EXIT:  if (sr_exit_ack_i) state <= ST_RECON;
        ST_RECON: begin
          state  <= ST_RUN;
          deep_q <= 1'b0;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign clk_tree_en_o  = !clocks_off;
  assign self_refresh_o = in_sr;
  assign cke_a_o        = !in_sr;
  assign cke_b_o        = !in_sr;
  assign cmd_idle_o     = in_sr;
  assign reconnect_o    = (state == ST_RECON);
  assign cfg_retain_o   = (state != ST_RUN);
  assign pwr_removed_o  = deep_q && clocks_off;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk #(
  parameter int NPROC = 2,
  parameter int SETTLE_CYCLES = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_grant_i,
  input logic             clk_stop_req_i,
  input logic             stop_clk_req_i,
  input logic [NPROC-1:0] proc_ready_i,
  input logic             sr_exit_ack_i,
  input logic             clk_tree_en_o,
  input logic             cke_a_o,
  input logic             cke_b_o,
  input logic             cmd_idle_o,
  input logic             self_refresh_o,
  input logic             reconnect_o,
  input logic             cfg_retain_o,
  input logic             pwr_removed_o
);
  logic [31:0] warm_cnt;
  always_ff @(posedge clk) begin
    if (rst || !(clk_tree_en_o && self_refresh_o)) warm_cnt <= '0;
    else warm_cnt <= warm_cnt + 1;
  end

  initial assert (NPROC == 1 || NPROC == 2);

  AST_ENTRY_ON_GRANT: assert property (@(posedge clk) disable iff (rst) $rose(self_refresh_o) |-> $past(stop_grant_i)); // R1
  AST_CKE_LOW_IN_SR: assert property (@(posedge clk) disable iff (rst) self_refresh_o |-> (!cke_a_o && !cke_b_o && cmd_idle_o)); // R2
  AST_CLK_ON_ORDER: assert property (@(posedge clk) disable iff (rst) $rose(clk_tree_en_o) |-> ($past(!clk_stop_req_i) && $past(!stop_clk_req_i))); // R3
  AST_CLK_OFF_ONLY_IN_SR: assert property (@(posedge clk) disable iff (rst) !clk_tree_en_o |-> self_refresh_o); // R4
  AST_SR_EXIT_READY: assert property (@(posedge clk) disable iff (rst) $fell(self_refresh_o) |-> ($past(&proc_ready_i) && $past(clk_tree_en_o))); // R5
  AST_SETTLE_DONE: assert property (@(posedge clk) disable iff (rst) $fell(self_refresh_o) |-> (warm_cnt >= 32'(SETTLE_CYCLES))); // R6
  AST_RECON_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) $rose(reconnect_o) |-> $past(sr_exit_ack_i)); // R7
  AST_RECON_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) reconnect_o |=> !reconnect_o); // R7
  AST_RETAIN_IN_SR: assert property (@(posedge clk) disable iff (rst) self_refresh_o |-> cfg_retain_o); // R8
  AST_PWR_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst) pwr_removed_o |-> (self_refresh_o && !clk_tree_en_o)); // R9
  AST_RESET_RUNNING: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (clk_tree_en_o && cke_a_o && cke_b_o && !self_refresh_o && !cfg_retain_o)); // R10
endmodule

bind sleep_seq sleep_seq_chk #(.NPROC(NPROC), .SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .stop_grant_i(stop_grant_i),
  .clk_stop_req_i(clk_stop_req_i), .stop_clk_req_i(stop_clk_req_i),
  .proc_ready_i(proc_ready_i), .sr_exit_ack_i(sr_exit_ack_i),
  .clk_tree_en_o(clk_tree_en_o), .cke_a_o(cke_a_o), .cke_b_o(cke_b_o),
  .cmd_idle_o(cmd_idle_o), .self_refresh_o(self_refresh_o),
  .reconnect_o(reconnect_o), .cfg_retain_o(cfg_retain_o),
  .pwr_removed_o(pwr_removed_o)
);

// File: tb/sleep_seq_bench.sv
module sleep_seq_bench;
  localparam int PERIOD = 10;
  localparam int NPROC  = 2;
  localparam int SETTLE = 16;

  logic clk = 0, rst = 1;
  logic stop_grant = 0, deep = 0, clk_stop = 0, stop_clk = 0, ack = 0;
  logic [NPROC-1:0] ready = '1;
  logic clk_en, cke_a, cke_b, idle, sr, recon, retain, pwr;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  sleep_seq #(.NPROC(NPROC), .SETTLE_CYCLES(SETTLE)) u_sleep_seq (
    .clk(clk), .rst(rst), .stop_grant_i(stop_grant), .deep_sleep_i(deep),
    .clk_stop_req_i(clk_stop), .stop_clk_req_i(stop_clk), .proc_ready_i(ready),
    .sr_exit_ack_i(ack), .clk_tree_en_o(clk_en), .cke_a_o(cke_a), .cke_b_o(cke_b),
    .cmd_idle_o(idle), .self_refresh_o(sr), .reconnect_o(recon),
    .cfg_retain_o(retain), .pwr_removed_o(pwr));

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enter(input bit d);
    clk_stop = 1; stop_clk = 1; deep = d; stop_grant = 1;
    tick();
    stop_grant = 0; deep = 0;
    chk(sr == 1, "R1 self-refresh after grant", sr, 1);
    chk({cke_a, cke_b, idle} == 3'b001, "R2 cke low, idle", {cke_a, cke_b, idle}, 1);
    chk(clk_en == 0, "R3 clocks off asleep", clk_en, 0);
    chk(retain == 1, "R8 retain asleep", retain, 1);
    chk(pwr == d, "R9 power flag", pwr, d);
  endtask

  task automatic finish_exit();
    tick(3);
    chk(sr == 0 && recon == 0, "R7 wait for ack", recon, 0);
    ack = 1;
    tick();
    chk(recon == 1, "R7 reconnect pulse", recon, 1);
    ack = 0;
    tick();
    chk(recon == 0 && retain == 0 && clk_en && cke_a, "R7 one-cycle pulse, running", recon, 0);
  endtask

  task automatic t_reset();
    tick(2);
    rst = 0;
    tick();
    chk({clk_en, cke_a, cke_b} == 3'b111, "R10 enables high", {clk_en, cke_a, cke_b}, 7);
    chk({sr, recon, retain, pwr} == 4'b0, "R10 others low", {sr, recon, retain, pwr}, 0);
  endtask

  task automatic t_light_cycle();
    enter(0);
    ready = '0;
    tick(5);
    chk(sr == 1 && clk_en == 0, "R3 stays asleep", clk_en, 0);
    clk_stop = 0;
    tick();
    chk(clk_en == 0, "R3 clocks wait for stop-clock", clk_en, 0);
    stop_clk = 0;
    tick();
    chk(clk_en == 1 && pwr == 0, "R3 clocks on after order", clk_en, 1);
    tick(SETTLE + 5);
    chk(sr == 1, "R5 no ready holds self-refresh", sr, 1);
    ready = 2'b01;
    tick(3);
    chk(sr == 1, "R5 partial ready holds", sr, 1);
    ready = '1;
    tick();
    chk(sr == 0 && cke_a && cke_b, "R5 exit with all ready", sr, 0);
    finish_exit();
  endtask

  task automatic t_settle_len();
    int n = 0;
    enter(0);
    clk_stop = 0;
    tick();
    stop_clk = 0;
    tick();
    while (clk_en && sr && n < 100) begin n++; tick(); end
    chk(n == SETTLE + 1, "R6 settle window length", n, SETTLE + 1);
    finish_exit();
  endtask

  task automatic t_wrong_order();
    enter(0);
    stop_clk = 0;
    tick(4);
    chk(clk_en == 0 && sr == 1, "R4 early stop-clock ignored", clk_en, 0);
    clk_stop = 0;
    tick(4);
    chk(clk_en == 0 && sr == 1, "R4 still asleep after clock-stop clears", clk_en, 0);
    stop_clk = 1;
    tick();
    chk(clk_en == 0, "R4 reasserted stop-clock", clk_en, 0);
    stop_clk = 0;
    tick();
    chk(clk_en == 1, "R4 clocks on after proper order", clk_en, 1);
    tick(SETTLE + 1);
    chk(sr == 0, "R6 exit after settle", sr, 0);
    finish_exit();
  endtask

  task automatic t_deep_cycle();
    enter(1);
    clk_stop = 0;
    tick();
    chk(pwr == 1, "R9 power flag held", pwr, 1);
    stop_clk = 0;
    tick();
    chk(pwr == 0 && clk_en == 1 && retain == 1, "R9 flag clears with clocks", pwr, 0);
    tick(SETTLE + 1);
    chk(sr == 0, "R5 deep exit", sr, 0);
    finish_exit();
    chk(pwr == 0, "R9 flag low running", pwr, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    t_reset();
    t_light_cycle();
    t_settle_len();
    t_wrong_order();
    t_deep_cycle();
    summary();
  end
endmodule